// File: doc/BRIEF.md
# Two-Tier Masked Interrupt Priority Controller

This block collects a non-maskable interrupt, an address-break request and a parameterised set of maskable request lines, and offers the CPU one pending request at a time. Each maskable line has a simple enable bit and a control level of 0 or 1. A level register sets the level, with one bit per pair of adjacent lines. Two mask flags, I and UI, give three masking tiers: everything accepted, only level-1 lines plus the two unmaskable sources, or only the unmaskable sources.

The chosen request is raised on `irq_req` together with a vector number. Both stay fixed until the CPU pulses `irq_ack`. On that same clock edge the block raises both mask flags, so nested acceptance is shut off until software lowers them again. Software can also write both flags directly. Software writes the level register through a separate write strobe.

Top module: `irq_tier_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `mask_i` is 1, `mask_ui` is 0, and every line is at control level 0.
- R2: Vector encoding: 0 is the non-maskable interrupt, 1 is the address break, and 2+k is maskable line k.
- R3: A level-0 line is accepted only while `mask_i` is 0.
- R4: A level-1 line is accepted while `mask_i` is 0 or `mask_ui` is 0. It is blocked only when both are 1.
- R5: The non-maskable and address-break requests are accepted in every mask state. With both flags at 1, no other vector is presented.
- R6: Priority order is: non-maskable, then level-1 lines (lowest index first), then address break, then level-0 lines (lowest index first).
- R7: Bit j of the level register sets the control level of lines 2j and 2j+1. The register is written whole through `lvl_we`.
- R8: Once `irq_req` is 1, it and `irq_vec` hold their values until `irq_ack` is seen, even if inputs, levels or flags change in the meantime.
- R9: An `irq_ack` while `irq_req` is 1 clears `irq_req` and sets both mask flags to 1 on the same edge. The next choice is made under the new flags.
- R10: `msk_we` loads `mask_i` and `mask_ui` from the write data on the next edge. If an acceptance happens on the same edge, the acceptance wins.
- R11: A maskable line whose `irq_en` bit is 0 is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable interrupt request |
| brk_req | input | 1 | Address-break request |
| irq_in | input | N_IRQ | Maskable request lines |
| irq_en | input | N_IRQ | Per-line enable |
| lvl_we | input | 1 | Level register write strobe |
| lvl_wdata | input | (N_IRQ+1)/2 | Level register write data, one bit per line pair |
| msk_we | input | 1 | Mask flag write strobe |
| msk_i_wdata | input | 1 | New value for I |
| msk_ui_wdata | input | 1 | New value for UI |
| irq_ack | input | 1 | CPU acceptance pulse |
| irq_req | output | 1 | Request pending to the CPU |
| irq_vec | output | $clog2(N_IRQ+2) | Vector of the pending request |
| mask_i | output | 1 | Current I flag |
| mask_ui | output | 1 | Current UI flag |

## Verification
The bench builds the block with N_IRQ set to 8. This gives four level bits, so every pairing of lines to a level bit can be exercised, including the top pair. With that setting, every mask tier can be shown against full request patterns: level-1 lines ahead of the address break, level-0 lines behind it, and the non-maskable request ahead of everything. It also shows that a presented vector survives a new higher-priority arrival, and that an acceptance overrides a mask write on the same edge.

// File: rtl/irq_tier_ctrl.sv
module irq_tier_ctrl #(
  parameter int N_IRQ = 16,
  localparam int LW = (N_IRQ + 1) / 2,
  localparam int VW = $clog2(N_IRQ + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_req,
  input  logic             brk_req,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             lvl_we,
  input  logic [LW-1:0]    lvl_wdata,
  input  logic             msk_we,
  input  logic             msk_i_wdata,
  input  logic             msk_ui_wdata,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [VW-1:0]    irq_vec,
  output logic             mask_i,
  output logic             mask_ui
);

  logic [LW-1:0]    lvl_q;
  logic [N_IRQ-1:0] src_lvl;
  logic [N_IRQ-1:0] ok1, ok0;
  logic [VW-1:0]    f1, f0, sel;
  logic             hit, req_q, mi_q, mui_q;
  logic [VW-1:0]    vec_q;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_lvl
    assign src_lvl[g] = lvl_q[g/2];
  end

  assign ok1 = irq_in & irq_en & src_lvl  & {N_IRQ{~(mi_q & mui_q)}};
  assign ok0 = irq_in & irq_en & ~src_lvl & {N_IRQ{~mi_q}};

  always_comb begin
    f1 = '0;
    f0 = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (ok1[i]) f1 = VW'(i);
      if (ok0[i]) f0 = VW'(i);
    end
    hit = 1'b1;
    if (nmi_req)      sel = '0;
    else if (|ok1)    sel = f1 + VW'(2);
    else if (brk_req) sel = VW'(1);
    else if (|ok0)    sel = f0 + VW'(2);
    else begin
      sel = '0;
      hit = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
      mi_q  <= 1'b1;
      mui_q <= 1'b0;
      lvl_q <= '0;
    end else begin
      if (lvl_we) lvl_q <= lvl_wdata;
      if (req_q && irq_ack) begin
        req_q <= 1'b0;
        mi_q  <= 1'b1;
        mui_q <= 1'b1;
      end else begin
        if (msk_we) begin
          mi_q  <= msk_i_wdata;
          mui_q <= msk_ui_wdata;
        end
        if (!req_q && hit) begin
          req_q <= 1'b1;
          vec_q <= sel;
        end
      end
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
  assign mask_i  = mi_q;
  assign mask_ui = mui_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && !irq_ack |=> req_q && $stable(vec_q));

  p_accept_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && irq_ack |=> mi_q && mui_q && !req_q);

  p_nmi_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q && nmi_req |=> req_q && vec_q == '0);

  p_full_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) && $past(mi_q && mui_q) |-> vec_q <= VW'(1));

  p_lvl0_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q && !nmi_req && !brk_req && mi_q && !(|(irq_in & irq_en & src_lvl))
    |=> !req_q);

endmodule

// File: tb/irq_tier_ctrl_tb_top.sv
module irq_tier_ctrl_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_req = 0, brk_req = 0, lvl_we = 0, msk_we = 0;
  logic msk_i_wdata = 0, msk_ui_wdata = 0, irq_ack = 0;
  logic [N-1:0] irq_in = '0, irq_en = '1;
  logic [3:0] lvl_wdata = '0;
  logic irq_req, mask_i, mask_ui;
  logic [3:0] irq_vec;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_tier_ctrl #(.N_IRQ(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .brk_req(brk_req),
    .irq_in(irq_in), .irq_en(irq_en), .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
    .msk_we(msk_we), .msk_i_wdata(msk_i_wdata), .msk_ui_wdata(msk_ui_wdata),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
    .mask_i(mask_i), .mask_ui(mask_ui));

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_lvl(logic [3:0] v);
    lvl_we = 1; lvl_wdata = v;
    @(negedge clk);
    lvl_we = 0;
  endtask

  task automatic serve(string tag, bit wi, bit wui, bit n, bit b,
                       logic [N-1:0] irq, bit exp_req, int exp_vec);
    nmi_req = 0; brk_req = 0; irq_in = '0;
    msk_we = 1; msk_i_wdata = wi; msk_ui_wdata = wui;
    @(negedge clk);
    msk_we = 0;
    nmi_req = n; brk_req = b; irq_in = irq;
    @(negedge clk);
    @(negedge clk);
    check({tag, " req"}, irq_req, exp_req);
    if (exp_req) begin
      check({tag, " vec"}, irq_vec, exp_vec);
      irq_ack = 1;
      @(negedge clk);
      irq_ack = 0;
      check({tag, " R9 mask after accept"}, {mask_i, mask_ui}, 3);
    end
    nmi_req = 0; brk_req = 0; irq_in = '0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 req at reset", irq_req, 0);
    check("R1 I at reset", mask_i, 1);
    check("R1 UI at reset", mask_ui, 0);
  endtask

  task automatic t_reset_tier;
    serve("R1 R3 level0 under reset mask", 1, 0, 0, 0, 8'h01, 0, 0);
    serve("R5 R2 brk under I=1", 1, 0, 0, 1, 8'h01, 1, 1);
  endtask

  task automatic t_full_mask;
    serve("R5 R6 nmi wins under full mask", 1, 1, 1, 1, 8'hFF, 1, 0);
    serve("R5 maskables blocked under full mask", 1, 1, 0, 0, 8'hFF, 0, 0);
  endtask

  task automatic t_priority;
    set_lvl(4'h2);
    serve("R6 level1 above brk", 0, 0, 0, 1, 8'hFF, 1, 4);
    serve("R6 brk above level0", 0, 0, 0, 1, 8'hF3, 1, 1);
    serve("R6 lowest level0 index", 0, 0, 0, 0, 8'hF2, 1, 3);
    serve("R6 R2 single level1", 0, 0, 0, 0, 8'h08, 1, 5);
    serve("R4 level1 with UI=0", 1, 0, 0, 0, 8'h09, 1, 5);
    serve("R4 level1 blocked I=1 UI=1", 1, 1, 0, 0, 8'h0C, 0, 0);
  endtask

  task automatic t_group;
    set_lvl(4'h4);
    serve("R7 bit2 lifts line5", 1, 0, 0, 0, 8'h60, 1, 7);
    serve("R7 other pairs stay level0", 1, 0, 0, 0, 8'h4C, 0, 0);
    set_lvl(4'h8);
    serve("R7 bit3 lifts line7", 1, 0, 0, 0, 8'h80, 1, 9);
    set_lvl(4'h0);
  endtask

  task automatic t_enable;
    irq_en = 8'hFD;
    serve("R11 disabled line ignored", 0, 0, 0, 0, 8'h02, 0, 0);
    serve("R11 enabled neighbour taken", 0, 0, 0, 0, 8'h06, 1, 4);
    irq_en = '1;
  endtask

  task automatic t_hold;
    msk_we = 1; msk_i_wdata = 0; msk_ui_wdata = 0;
    @(negedge clk);
    msk_we = 0;
    check("R10 write I=0 UI=0", {mask_i, mask_ui}, 0);
    irq_in = 8'h01;
    @(negedge clk);
    @(negedge clk);
    check("R8 initial vec", irq_vec, 2);
    nmi_req = 1; irq_in = 8'h81;
    set_lvl(4'hF);
    repeat (3) @(negedge clk);
    check("R8 req held", irq_req, 1);
    check("R8 vec held", irq_vec, 2);
    nmi_req = 0; irq_in = 8'h01;
    set_lvl(4'h0);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    check("R9 mask set by accept", {mask_i, mask_ui}, 3);
    repeat (2) @(negedge clk);
    check("R9 next choice under new mask", irq_req, 0);
    irq_in = '0;
    @(negedge clk);
  endtask

  task automatic t_collision;
    msk_we = 1; msk_i_wdata = 0; msk_ui_wdata = 1;
    @(negedge clk);
    msk_we = 0;
    check("R10 write I=0 UI=1", {mask_i, mask_ui}, 1);
    irq_in = 8'h01;
    @(negedge clk);
    @(negedge clk);
    check("R10 req before collision", irq_req, 1);
    irq_in = '0;
    irq_ack = 1; msk_we = 1; msk_i_wdata = 0; msk_ui_wdata = 0;
    @(negedge clk);
    irq_ack = 0; msk_we = 0;
    check("R10 accept beats write", {mask_i, mask_ui}, 3);
    check("R10 req cleared", irq_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reset_tier();
    t_full_mask();
    t_priority();
    t_group();
    t_enable();
    t_hold();
    t_collision();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule